// File: doc/BRIEF.md
# Configuration Completion Collector

This block sits on the answer path of a configuration access engine. Once the request side has sent a configuration read or write, it issues a wait command to this block. The block then watches an incoming stream of 32-bit dwords, each flagged with optional start and end markers. It gathers one completion packet, from the dword with the start marker through the dword with the end marker. It then decodes the status and byte-count fields from the second dword and hands back a single result.

The result port carries a data word, a one-cycle done strobe and an error flag. For a read, the data is the fourth dword of the packet when the completion reports success with a four-byte count. A failed completion produces all ones. A write completion only confirms that the access finished. When no complete packet turns up within a fixed number of poll cycles after the wait command, the block reports a timeout error instead.

Top module: `cfg_cpl_collector`

## Requirements
- R1: After reset `busy`, `res_done` and `res_err` are 0 and `res_data` is 0.
- R2: A `cmd_start` pulse is accepted only while `busy` is 0. `busy` is 1 from the next cycle, and the value of `cmd_read` is latched at that point. `cmd_start` while `busy` is 1 has no effect on the command in progress.
- R3: Stream beats (`rx_valid`=1) seen while idle, and beats before the first one with `rx_sop`=1 while waiting, are ignored. Collection starts with the start-marked beat itself.
- R4: The beat with `rx_eop`=1 ends the packet and is stored. `res_done` rises on the second rising edge that follows the edge sampling that beat, counting the sampling edge as the first. At the same edge `busy` falls. A single beat carrying both markers is a full packet.
- R5: For a read, a non-zero completion status in bits 15:13 of the second dword gives `res_data` = all ones with `res_err` = 0.
- R6: For a read with status 0, byte count (bits 11:0 of the second dword) equal to 4, and at least four dwords collected, `res_data` equals the fourth dword of the packet.
- R7: For a read with status 0 where the byte count is not 4, or fewer than four dwords were collected, `res_data` is 0 and `res_err` is 0.
- R8: For a write completion, `res_data` is 0 and `res_err` is 0 whatever the status or contents.
- R9: If the end beat has not been sampled by the POLL_LIMIT-th rising edge after acceptance, that edge raises `res_done` with `res_err` = 1 and `res_data` all ones (POLL_LIMIT = 20000 by default).
- R10: The poll window restarts with every accepted command, so a command that follows a timeout gets the full window again.
- R11: Dwords beyond the fourth are not stored but are still checked for the end marker, and the fourth dword remains the read data.
- R12: A start-marked beat during collection discards what was gathered so far and begins a new packet with that beat.
- R13: `res_done` is high for one cycle only, and `res_err` is never high without `res_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Wait-command pulse from the request side |
| cmd_read | input | 1 | 1 = read completion expected, 0 = write |
| busy | output | 1 | A command is in progress |
| rx_valid | input | 1 | Stream beat present |
| rx_data | input | DW_W | Stream dword |
| rx_sop | input | 1 | Beat is the first dword of a packet |
| rx_eop | input | 1 | Beat is the last dword of a packet |
| res_done | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Timeout error, valid with `res_done` |
| res_data | output | DW_W | Result data, valid with `res_done` |

## Verification
The checker assumes that `cmd_start` is a clean synchronous pulse and that every stream input is driven to a known value on every cycle after reset. It makes no assumption about how the beats are framed, since stray, repeated or missing markers are all legal input. The bench changes inputs only on falling edges and holds them for a full cycle. It sends `cmd_start` only as single-cycle pulses, and its one overlapping command is timed so that it lands while `busy` is already high. Framing faults appear only where a requirement calls for them: beats before the start marker, extra dwords, and a restart in mid-packet.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HUNT    = 2'd1,
      ST_COLLECT = 2'd2,
      ST_REPORT  = 2'd3
   } cfgc_state_e;

   localparam int unsigned DATA_SLOT_IDX = 3;

endpackage

// File: rtl/cfgc_beat_store.sv
module cfgc_beat_store #(
   parameter int unsigned DW_W  = 32,
   parameter int unsigned SLOTS = 4,
   localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_en,
   input  logic                        cap_first,
   input  logic [DW_W-1:0]             cap_data,
   output logic [SLOTS-1:0][DW_W-1:0]  slots,
   output logic [CNT_W-1:0]            filled
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filled <= '0;
      end else if (cap_en) begin
         if (cap_first) begin
            filled <= CNT_W'(1);
         end else if (filled < CNT_W'(SLOTS)) begin
            filled <= filled + CNT_W'(1);
         end
      end
   end

   for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slots[gi] <= '0;
         end else if (cap_en) begin
            if (cap_first) begin
               slots[gi] <= (gi == 0) ? cap_data : '0;
            end else if (filled == CNT_W'(gi)) begin
               slots[gi] <= cap_data;
            end
         end
      end
   end

endmodule

// File: rtl/cfgc_poll_timer.sv
module cfgc_poll_timer #(
   parameter int unsigned POLL_LIMIT = 20000,
   localparam int unsigned PT_W = $clog2(POLL_LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expire
);

   logic [PT_W-1:0] polls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         polls <= '0;
      end else if (restart) begin
         polls <= '0;
      end else if (run && !expire) begin
         polls <= polls + PT_W'(1);
      end
   end

   assign expire = run && (polls == PT_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/cfgc_result_decode.sv
module cfgc_result_decode
   import cfgc_pkg::*;
#(
   parameter int unsigned DW_W      = 32,
   parameter int unsigned SLOTS     = 4,
   parameter int unsigned STAT_LSB  = 13,
   parameter int unsigned STAT_W    = 3,
   parameter int unsigned BCNT_W    = 12,
   parameter int unsigned BCNT_FULL = 4,
   localparam int unsigned CNT_W    = $clog2(SLOTS + 1)
) (
   input  logic [SLOTS-1:0][DW_W-1:0] slots,
   input  logic [CNT_W-1:0]           filled,
   input  logic                       is_read,
   output logic [DW_W-1:0]            value
);

   logic [STAT_W-1:0] cpl_status;
   logic [BCNT_W-1:0] cpl_bytes;
   logic              have_data;

   assign cpl_status = slots[1][STAT_LSB +: STAT_W];
   assign cpl_bytes  = slots[1][BCNT_W-1:0];
   assign have_data  = filled > CNT_W'(DATA_SLOT_IDX);

   always_comb begin
      if (!is_read) begin
         value = '0;
      end else if (cpl_status != '0) begin
         value = '1;
      end else if ((cpl_bytes == BCNT_W'(BCNT_FULL)) && have_data) begin
         value = slots[DATA_SLOT_IDX];
      end else begin
         value = '0;
      end
   end

endmodule

// File: rtl/cfg_cpl_collector.sv
module cfg_cpl_collector
   import cfgc_pkg::*;
#(
   parameter int unsigned DW_W       = 32,
   parameter int unsigned SLOTS      = 4,
   parameter int unsigned POLL_LIMIT = 20000,
   parameter int unsigned STAT_LSB   = 13,
   parameter int unsigned STAT_W     = 3,
   parameter int unsigned BCNT_W     = 12,
   parameter int unsigned BCNT_FULL  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_start,
   input  logic            cmd_read,
   output logic            busy,
   input  logic            rx_valid,
   input  logic [DW_W-1:0] rx_data,
   input  logic            rx_sop,
   input  logic            rx_eop,
   output logic            res_done,
   output logic            res_err,
   output logic [DW_W-1:0] res_data
);

   localparam int unsigned CNT_W = $clog2(SLOTS + 1);

   if (SLOTS < DATA_SLOT_IDX + 1) begin : g_bad_slots
      $error("SLOTS must hold at least four dwords");
   end
   if (POLL_LIMIT < 2) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 2");
   end
   if (STAT_LSB + STAT_W > DW_W || BCNT_W > DW_W) begin : g_bad_fields
      $error("status or byte-count field outside the dword");
   end

   cfgc_state_e              state;
   logic                     want_read;
   logic                     accept;
   logic                     waiting;
   logic                     take_beat;
   logic                     end_beat;
   logic                     expire;
   logic                     timed_out;
   logic [SLOTS-1:0][DW_W-1:0] slots;
   logic [CNT_W-1:0]         filled;
   logic [DW_W-1:0]          decoded;

   assign accept    = cmd_start && (state == ST_IDLE);
   assign waiting   = (state == ST_HUNT) || (state == ST_COLLECT);
   assign take_beat = rx_valid &&
                      (((state == ST_HUNT) && rx_sop) || (state == ST_COLLECT));
   assign end_beat  = take_beat && rx_eop;
   assign timed_out = expire;
   assign busy      = (state != ST_IDLE);

   cfgc_beat_store #(
      .DW_W  (DW_W),
      .SLOTS (SLOTS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (take_beat),
      .cap_first (rx_sop),
      .cap_data  (rx_data),
      .slots     (slots),
      .filled    (filled)
   );

   cfgc_poll_timer #(
      .POLL_LIMIT (POLL_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (waiting && !end_beat),
      .expire  (expire)
   );

   cfgc_result_decode #(
      .DW_W      (DW_W),
      .SLOTS     (SLOTS),
      .STAT_LSB  (STAT_LSB),
      .STAT_W    (STAT_W),
      .BCNT_W    (BCNT_W),
      .BCNT_FULL (BCNT_FULL)
   ) u_decode (
      .slots   (slots),
      .filled  (filled),
      .is_read (want_read),
      .value   (decoded)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         want_read <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state     <= ST_HUNT;
                  want_read <= cmd_read;
               end
            end
            ST_HUNT, ST_COLLECT: begin
               if (end_beat) begin
                  state <= ST_REPORT;
               end else if (timed_out) begin
                  state <= ST_IDLE;
               end else if (take_beat) begin
                  state <= ST_COLLECT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_done <= 1'b0;
         res_err  <= 1'b0;
         res_data <= '0;
      end else begin
         res_done <= (state == ST_REPORT) || timed_out;
         res_err  <= timed_out;
         if (state == ST_REPORT) begin
            res_data <= decoded;
         end else if (timed_out) begin
            res_data <= '1;
         end
      end
   end

endmodule

// File: rtl/cfgc_checker.sv
module cfgc_checker #(
   parameter int unsigned DW_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_start,
   input logic            busy,
   input logic            res_done,
   input logic            res_err,
   input logic [DW_W-1:0] res_data
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done); // R13

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_done); // R13

   AST_CMD_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy) |=> busy); // R2

   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !busy); // R4

   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_done) |-> $past(busy)); // R4

   AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_data == {DW_W{1'b1}})); // R9

endmodule

bind cfg_cpl_collector cfgc_checker #(.DW_W(DW_W)) u_cfgc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_start (cmd_start),
   .busy      (busy),
   .res_done  (res_done),
   .res_err   (res_err),
   .res_data  (res_data)
);

// File: tb/cfg_cpl_collector_tb_top.sv
`timescale 1ns/1ps
module cfg_cpl_collector_tb_top;

   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_read = 1'b0;
   logic        busy;
   logic        rx_valid = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_sop = 1'b0;
   logic        rx_eop = 1'b0;
   logic        res_done;
   logic        res_err;
   logic [31:0] res_data;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   cfg_cpl_collector dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_read  (cmd_read),
      .busy      (busy),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_sop    (rx_sop),
      .rx_eop    (rx_eop),
      .res_done  (res_done),
      .res_err   (res_err),
      .res_data  (res_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input bit rd);
      cmd_start = 1'b1;
      cmd_read  = rd;
      @(posedge clk);
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic beat(input logic [31:0] d, input bit s, input bit e);
      rx_valid = 1'b1;
      rx_data  = d;
      rx_sop   = s;
      rx_eop   = e;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sop   = 1'b0;
      rx_eop   = 1'b0;
   endtask

   task automatic expect_result(input string req, input logic [31:0] exp);
      @(posedge clk);
      @(negedge clk);
      chk(res_done === 1'b1, req, {31'd0, res_done}, 32'd1);
      chk(res_err === 1'b0 && res_data === exp, req, res_data, exp);
      chk(busy === 1'b0, req, {31'd0, busy}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk(res_done === 1'b0, {req, " R13 single"}, {31'd0, res_done}, 32'd0);
   endtask

   function automatic logic [31:0] model(input bit rd, input int st, input int bc,
                                         input int ndw, input logic [31:0] d3);
      if (!rd) return 32'd0;
      if (st != 0) return 32'hFFFF_FFFF;
      if (bc == 4 && ndw >= 4) return d3;
      return 32'd0;
   endfunction

   function automatic logic [31:0] dw1(input int st, input int bc);
      return 32'h5A5A_1000 | (32'(st) << 13) | 32'(bc);
   endfunction

   initial begin
      int cyc = 0;
      while (cyc < 150000 && !ended) begin
         @(posedge clk);
         cyc++;
      end
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d3;
      logic [31:0] exp;
      int bcs[4];
      bcs = '{3, 4, 5, 32'h104};
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && res_done === 1'b0 && res_err === 1'b0, "R1 flags",
          {29'd0, busy, res_done, res_err}, 32'd0);
      chk(res_data === 32'd0, "R1 data", res_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 beats while idle are ignored
      beat(32'h1111_0000, 1'b1, 1'b1);
      @(posedge clk); @(negedge clk);
      chk(res_done === 1'b0 && busy === 1'b0, "R3 idle beat",
          {30'd0, res_done, busy}, 32'd0);

      // R4 R5 R6 R7 R8 sweep over status, byte count and direction
      for (int rd = 0; rd < 2; rd++) begin
         for (int st = 0; st < 8; st++) begin
            for (int bi = 0; bi < 4; bi++) begin
               d3 = 32'hC0DE_0000 + 32'(rd * 100 + st * 10 + bi);
               exp = model(rd[0], st, bcs[bi], 4, d3);
               issue(rd[0]);
               chk(busy === 1'b1, "R2 busy", {31'd0, busy}, 32'd1);
               beat(32'h4A00_0001, 1'b1, 1'b0);
               beat(dw1(st, bcs[bi]), 1'b0, 1'b0);
               beat(32'h0100_0000, 1'b0, 1'b0);
               beat(d3, 1'b0, 1'b1);
               expect_result(rd == 0 ? "R8 write" :
                             (st != 0 ? "R5 status" :
                              (bcs[bi] == 4 ? "R6 data" : "R7 bytecount")), exp);
            end
         end
      end

      // R7 short packets of one, two and three dwords
      for (int n = 1; n <= 3; n++) begin
         issue(1'b1);
         for (int k = 0; k < n; k++) begin
            beat(k == 1 ? dw1(0, 4) : 32'h7700_0000 + 32'(k), k == 0, k == n - 1);
         end
         expect_result("R7 short", 32'd0);
      end

      // R3 junk before start marker; R2 second cmd while busy ignored
      issue(1'b1);
      cmd_start = 1'b1; cmd_read = 1'b0;
      beat(32'hDEAD_0001, 1'b0, 1'b1);
      cmd_start = 1'b0;
      beat(32'hDEAD_0002, 1'b0, 1'b0);
      @(posedge clk); @(negedge clk);
      chk(res_done === 1'b0 && busy === 1'b1, "R3 pre-start",
          {30'd0, res_done, busy}, 32'd1);
      beat(32'h4A00_0001, 1'b1, 1'b0);
      beat(dw1(0, 4), 1'b0, 1'b0);
      beat(32'h0, 1'b0, 1'b0);
      beat(32'hABCD_1234, 1'b0, 1'b1);
      expect_result("R2 R3 read kept", 32'hABCD_1234);

      // R11 extra dwords dropped
      issue(1'b1);
      beat(32'h4A00_0001, 1'b1, 1'b0);
      beat(dw1(0, 4), 1'b0, 1'b0);
      beat(32'h0, 1'b0, 1'b0);
      beat(32'h600D_0004, 1'b0, 1'b0);
      beat(32'hBAD0_0005, 1'b0, 1'b0);
      beat(32'hBAD0_0006, 1'b0, 1'b1);
      expect_result("R11 extra", 32'h600D_0004);

      // R12 restart on a new start marker
      issue(1'b1);
      beat(32'h4A00_0001, 1'b1, 1'b0);
      beat(dw1(2, 4), 1'b0, 1'b0);
      beat(32'h4A00_0009, 1'b1, 1'b0);
      beat(dw1(0, 4), 1'b0, 1'b0);
      beat(32'h0, 1'b0, 1'b0);
      beat(32'h5151_7777, 1'b0, 1'b1);
      expect_result("R12 restart", 32'h5151_7777);

      // R9 timeout after LIMIT edges
      issue(1'b1);
      begin
         int seen = -1;
         for (int c = 1; c <= LIMIT + 2; c++) begin
            @(posedge clk); @(negedge clk);
            if (res_done === 1'b1 && seen < 0) begin
               seen = c;
               chk(res_err === 1'b1, "R9 err", {31'd0, res_err}, 32'd1);
               chk(res_data === 32'hFFFF_FFFF, "R9 data", res_data, 32'hFFFF_FFFF);
            end
         end
         chk(seen == LIMIT, "R9 timing", 32'(seen), 32'(LIMIT));
      end

      // R10 fresh window after timeout: packet ends at edge LIMIT-1
      issue(1'b1);
      repeat (LIMIT - 5) begin @(posedge clk); @(negedge clk); end
      chk(res_done === 1'b0, "R10 no early timeout", {31'd0, res_done}, 32'd0);
      beat(32'h4A00_0001, 1'b1, 1'b0);
      beat(dw1(0, 4), 1'b0, 1'b0);
      beat(32'h0, 1'b0, 1'b0);
      beat(32'h1234_5678, 1'b0, 1'b1);
      expect_result("R10 window", 32'h1234_5678);

      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule